// File: doc/BRIEF.md
# Frequency Lock Detector With Fallback

This block decides whether a clock-recovery loop has locked onto an incoming serial stream. It does this by checking the frequency of the recovered bit clock against a local reference clock. The reference clock runs the control logic. Each measurement window lasts a fixed power-of-two number of reference cycles. During the window, a free-running counter in the recovered-clock domain advances. Its value crosses into the reference domain as a Gray code, and the block takes the difference between two window boundaries. That difference is compared with the count expected for the clock ratio picked by a 2-bit divider select.

A small state machine steers the loop through four states: training on the reference (`S_TRAIN`), a trial window on data (`S_PROBE`), a confirming window (`S_CONFIRM`) and locked (`S_LOCKED`). The transitions are:
- `S_TRAIN` to `S_PROBE` at the end of the training window.
- `S_PROBE` to `S_CONFIRM`, or `S_CONFIRM` to `S_LOCKED`, when the window count is in range.
- `S_PROBE`, `S_CONFIRM` or `S_LOCKED` back to `S_TRAIN` when the window count is out of range.
- `S_LOCKED` stays in `S_LOCKED` while the count stays in range.
- Any state to `S_TRAIN` while carrier-detect is low.

The steering output tells the analog loop whether to follow the reference-derived frequency or to track data. A carrier-detect input overrides everything: it gates the retimed data, the lock indicator and the steering. A clock-select mux picks the transmit clock from the recovered clock or from the synthesized reference-derived clock.

Top module: `freq_lock_detector`

## Requirements
- R1: A synchronous active-high reset in the reference domain sets state `S_TRAIN`, drives `lock_out` and `track_data` low, and restarts the measurement window.
- R2: The expected count per window is (2^WIN_LOG2) times the ratio chosen by `div_sel`. Value 0 (binary 00) selects 8, 1 (01) selects 10, 2 (10) selects 16 and 3 (11) selects 20.
- R3: A window count is in range when its absolute difference from the expected count is no more than the expected count shifted right by TOL_SHIFT. A difference exactly on that limit is in range.
- R4: After a restart, `S_TRAIN` lasts exactly one window: `track_data` rises at the 2^WIN_LOG2-th reference edge after the restart. A failed `S_PROBE` window returns to `S_TRAIN`, and the loop is then released to data again one window later.
- R5: `lock_out` rises only after two consecutive in-range windows (`S_PROBE` then `S_CONFIRM`). It stays low during the confirming window.
- R6: In `S_LOCKED`, one out-of-range window moves the block to `S_TRAIN` at that window's end. `lock_out` stays high until that edge.
- R7: While `carrier_ok` is low, `lock_out` and `track_data` are low in the same cycle and the state returns to `S_TRAIN`. When `carrier_ok` returns high, a new full window starts.
- R8: `data_out` is `data_in` registered on the rising edge of `rec_clk`. It is held low whenever `carrier_ok` is low.
- R9: `tx_clk` follows `rec_clk` when `clk_sel` is 1 and `synth_clk` when `clk_sel` is 0.
- R10: If the recovered clock stops while locked, the next full window fails and lock is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock; runs window and state logic |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| rec_clk | input | 1 | Recovered bit clock from the loop |
| synth_clk | input | 1 | Synthesized reference-derived clock |
| div_sel | input | 2 | Expected clock ratio select (8, 10, 16, 20) |
| carrier_ok | input | 1 | Carrier detect; low forces training and gates data and lock |
| data_in | input | 1 | Recovered serial data from the loop |
| clk_sel | input | 1 | Transmit clock source: 1 recovered, 0 synthesized |
| data_out | output | 1 | Retimed data, low while carrier is absent |
| tx_clk | output | 1 | Selected transmit clock |
| lock_out | output | 1 | High while locked and carrier present |
| track_data | output | 1 | 1: loop tracks data, 0: loop trains on reference |

## Verification
State changes fall on window boundaries. A boundary is the 2^WIN_LOG2-th reference edge after a restart, counted from the first edge that sees reset released or carrier high. The bench keeps an edge counter from each restart and checks `track_data` just before and just after the first boundary. All other state checks sample in the middle of a window, so one edge of phase uncertainty does not change the result. `lock_out` and `track_data` respond to `carrier_ok` in the same cycle, and `data_out` follows `data_in` after one `rec_clk` edge. Both are sampled a nanosecond after the drive, between reference edges. The recovered-clock half periods are chosen so that each window count lands either about 1% or about 5% away from the expected value, against a limit of about 1.6%. A bench function predicts each window's outcome from the half period.

// File: rtl/fld_pkg.sv
package fld_pkg;

    typedef enum logic [1:0] {
        S_TRAIN   = 2'd0,
        S_PROBE   = 2'd1,
        S_CONFIRM = 2'd2,
        S_LOCKED  = 2'd3
    } fld_state_e;

    localparam int unsigned RATIO_W = 5;

    // divider select -> recovered/reference frequency ratio
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [1:0] sel);
        logic [RATIO_W-1:0] r;
        unique case (sel)
            2'b00: r = 5'd8;
            2'b01: r = 5'd10;
            2'b10: r = 5'd16;
            2'b11: r = 5'd20;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fld_rec_counter.sv
module fld_rec_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             rec_clk,
    input  logic             rst,
    output logic [CNT_W-1:0] gray_o
);
    logic [1:0]       rst_pipe;
    logic             rec_rst;
    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nx;
    logic [CNT_W-1:0] gray_q;

    // bring the reference-domain reset into the recovered domain
    always_ff @(posedge rec_clk) begin
        rst_pipe <= {rst_pipe[0], rst};
    end
    assign rec_rst = rst_pipe[1];

    assign bin_nx = bin_q + 1'b1;

    always_ff @(posedge rec_clk) begin
        if (rec_rst) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nx;
            gray_q <= bin_nx ^ (bin_nx >> 1);
        end
    end

    assign gray_o = gray_q;
endmodule

// File: rtl/fld_gray_sync.sv
module fld_gray_sync #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             ref_clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] gray_i,
    output logic [CNT_W-1:0] bin_o
);
    logic [CNT_W-1:0] meta_q;
    logic [CNT_W-1:0] sync_q;

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_i;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the xor of all Gray bits at or above it
    assign bin_o[CNT_W-1] = sync_q[CNT_W-1];
    for (genvar i = CNT_W - 2; i >= 0; i--) begin : g_g2b
        assign bin_o[i] = bin_o[i+1] ^ sync_q[i];
    end
endmodule

// File: rtl/fld_window_meter.sv
module fld_window_meter
    import fld_pkg::*;
#(
    parameter int unsigned WIN_LOG2  = 10,
    parameter int unsigned TOL_SHIFT = 10,
    parameter int unsigned CNT_W     = 16
) (
    input  logic             ref_clk,
    input  logic             rst,
    input  logic             carrier_ok,
    input  logic [1:0]       div_sel,
    input  logic [CNT_W-1:0] cur_cnt,
    output logic             win_end,
    output logic             in_range
);
    logic [WIN_LOG2-1:0] win_q;
    logic [CNT_W-1:0]    prev_q;
    logic [CNT_W-1:0]    ratio_ext;
    logic [CNT_W-1:0]    expected;
    logic [CNT_W-1:0]    measured;
    logic [CNT_W-1:0]    err;
    logic [CNT_W-1:0]    tol;

    // window position; held at zero and baseline refreshed while idle
    always_ff @(posedge ref_clk) begin
        if (rst || !carrier_ok) begin
            win_q  <= '0;
            prev_q <= cur_cnt;
        end else begin
            win_q <= win_q + 1'b1;
            if (win_end) begin
                prev_q <= cur_cnt;
            end
        end
    end

    assign win_end = carrier_ok && (&win_q);

    assign ratio_ext = {{(CNT_W-RATIO_W){1'b0}}, ratio_of(div_sel)};
    assign expected  = ratio_ext << WIN_LOG2;
    assign measured  = cur_cnt - prev_q;
    assign err       = (measured >= expected) ? (measured - expected)
                                              : (expected - measured);
    assign tol       = expected >> TOL_SHIFT;
    assign in_range  = (err <= tol);
endmodule

// File: rtl/fld_lock_fsm.sv
module fld_lock_fsm
    import fld_pkg::*;
(
    input  logic       ref_clk,
    input  logic       rst,
    input  logic       carrier_ok,
    input  logic       win_end,
    input  logic       in_range,
    output fld_state_e state_o,
    output logic       lock_o,
    output logic       track_o
);
    fld_state_e state_q;
    fld_state_e state_nx;
    logic       lock_raw;
    logic       track_raw;

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            state_q <= S_TRAIN;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        if (!carrier_ok) begin
            state_nx = S_TRAIN;
        end else if (win_end) begin
            unique case (state_q)
                S_TRAIN:   state_nx = S_PROBE;
                S_PROBE:   state_nx = in_range ? S_CONFIRM : S_TRAIN;
                S_CONFIRM: state_nx = in_range ? S_LOCKED  : S_TRAIN;
                S_LOCKED:  state_nx = in_range ? S_LOCKED  : S_TRAIN;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            S_TRAIN:   begin lock_raw = 1'b0; track_raw = 1'b0; end
            S_PROBE:   begin lock_raw = 1'b0; track_raw = 1'b1; end
            S_CONFIRM: begin lock_raw = 1'b0; track_raw = 1'b1; end
            S_LOCKED:  begin lock_raw = 1'b1; track_raw = 1'b1; end
        endcase
    end

    assign lock_o  = lock_raw  & carrier_ok;
    assign track_o = track_raw & carrier_ok;
    assign state_o = state_q;
endmodule

// File: rtl/freq_lock_detector.sv
module freq_lock_detector
    import fld_pkg::*;
#(
    parameter int unsigned WIN_LOG2  = 10,
    parameter int unsigned TOL_SHIFT = 10
) (
    input  logic       ref_clk,
    input  logic       rst,
    input  logic       rec_clk,
    input  logic       synth_clk,
    input  logic [1:0] div_sel,
    input  logic       carrier_ok,
    input  logic       data_in,
    input  logic       clk_sel,
    output logic       data_out,
    output logic       tx_clk,
    output logic       lock_out,
    output logic       track_data
);
    // headroom of one bit above the largest ratio (20 < 32)
    localparam int unsigned CNT_W = WIN_LOG2 + 6;

    logic [CNT_W-1:0] rec_gray;
    logic [CNT_W-1:0] cur_cnt;
    logic             win_end;
    logic             in_range;
    fld_state_e       fsm_state;
    logic             data_q;

    fld_rec_counter #(.CNT_W(CNT_W)) u_rec_cnt (
        .rec_clk (rec_clk),
        .rst     (rst),
        .gray_o  (rec_gray)
    );

    fld_gray_sync #(.CNT_W(CNT_W)) u_sync (
        .ref_clk (ref_clk),
        .rst     (rst),
        .gray_i  (rec_gray),
        .bin_o   (cur_cnt)
    );

    fld_window_meter #(
        .WIN_LOG2  (WIN_LOG2),
        .TOL_SHIFT (TOL_SHIFT),
        .CNT_W     (CNT_W)
    ) u_meter (
        .ref_clk    (ref_clk),
        .rst        (rst),
        .carrier_ok (carrier_ok),
        .div_sel    (div_sel),
        .cur_cnt    (cur_cnt),
        .win_end    (win_end),
        .in_range   (in_range)
    );

    fld_lock_fsm u_fsm (
        .ref_clk    (ref_clk),
        .rst        (rst),
        .carrier_ok (carrier_ok),
        .win_end    (win_end),
        .in_range   (in_range),
        .state_o    (fsm_state),
        .lock_o     (lock_out),
        .track_o    (track_data)
    );

    // retiming flop, input forced low without carrier
    always_ff @(posedge rec_clk) begin
        data_q <= data_in & carrier_ok;
    end
    assign data_out = data_q & carrier_ok;

    assign tx_clk = clk_sel ? rec_clk : synth_clk;
endmodule

// File: rtl/fld_checker.sv
module fld_checker
    import fld_pkg::*;
(
    input logic       ref_clk,
    input logic       rst,
    input logic       carrier_ok,
    input logic       lock_out,
    input logic       track_data,
    input fld_state_e state,
    input logic       win_end,
    input logic       in_range
);
    a_r1_reset_idle: assert property (@(posedge ref_clk)
        rst |=> (!lock_out && !track_data));

    a_r4_train_to_probe: assert property (@(posedge ref_clk) disable iff (rst)
        (state == S_TRAIN && win_end) |=> (state == S_PROBE));

    a_r4_probe_fail: assert property (@(posedge ref_clk) disable iff (rst)
        (state == S_PROBE && win_end && !in_range) |=> (state == S_TRAIN));

    a_r5_lock_after_confirm: assert property (@(posedge ref_clk) disable iff (rst)
        $rose(lock_out) |-> ($past(state) == S_CONFIRM));

    a_r6_drop_on_fail: assert property (@(posedge ref_clk) disable iff (rst)
        (state == S_LOCKED && win_end && !in_range) |=> (state == S_TRAIN && !lock_out));

    a_r7_carrier_forces_train: assert property (@(posedge ref_clk) disable iff (rst)
        !carrier_ok |=> (state == S_TRAIN && !lock_out));
endmodule

bind freq_lock_detector fld_checker u_chk (
    .ref_clk    (ref_clk),
    .rst        (rst),
    .carrier_ok (carrier_ok),
    .lock_out   (lock_out),
    .track_data (track_data),
    .state      (fsm_state),
    .win_end    (win_end),
    .in_range   (in_range)
);

// File: tb/freq_lock_detector_test.sv
`timescale 1ns/1ps
module freq_lock_detector_test;
    localparam int WL = 8;
    localparam int TS = 6;
    localparam int N  = 1 << WL;

    logic       ref_clk = 1'b0;
    logic       rst = 1'b1;
    logic       rec_clk = 1'b0;
    logic       synth_clk = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       carrier_ok = 1'b1;
    logic       data_in = 1'b0;
    logic       clk_sel = 1'b0;
    logic       data_out, tx_clk, lock_out, track_data;

    int  errors = 0;
    int  checks = 0;
    int  pos = 0;
    int  rec_half_ps = 250;
    bit  rec_run = 1'b1;
    bit  done = 1'b0;

    freq_lock_detector #(.WIN_LOG2(WL), .TOL_SHIFT(TS)) uut (
        .ref_clk(ref_clk), .rst(rst), .rec_clk(rec_clk), .synth_clk(synth_clk),
        .div_sel(div_sel), .carrier_ok(carrier_ok), .data_in(data_in),
        .clk_sel(clk_sel), .data_out(data_out), .tx_clk(tx_clk),
        .lock_out(lock_out), .track_data(track_data)
    );

    always #2 ref_clk = ~ref_clk;          // 250 MHz reference
    always #1.5 synth_clk = ~synth_clk;
    always begin
        if (rec_run) begin
            #(real'(rec_half_ps) / 1000.0) rec_clk = ~rec_clk;
        end else begin
            @(posedge rec_run);
        end
    end

    function automatic int ratio_model(input logic [1:0] s);
        case (s)
            2'd0: return 8;
            2'd1: return 10;
            2'd2: return 16;
            default: return 20;
        endcase
    endfunction

    function automatic bit pass_model(input logic [1:0] s, input int half);
        int cnt, exp_c, tol, d;
        cnt   = (N * 4000) / (2 * half);
        exp_c = N * ratio_model(s);
        tol   = exp_c >> TS;
        d     = (cnt > exp_c) ? cnt - exp_c : exp_c - cnt;
        return d <= tol;
    endfunction

    function automatic int half_for(input logic [1:0] s, input int kind);
        int nom;
        nom = 2000 / ratio_model(s);
        case (kind)
            0: return nom;                       // nominal
            1: return nom + (nom / 100);         // ~1% slow
            2: return nom - (nom / 100);         // ~1% fast
            3: return nom - (nom / 20);          // ~5% fast
            default: return nom + (nom / 20);    // ~5% slow
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: %s got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge ref_clk);
            pos++;
        end
    endtask

    task automatic goto(input int p);
        while (pos < p) tick(1);
    endtask

    task automatic restart();
        carrier_ok = 1'b0;
        tick(3);
        carrier_ok = 1'b1;
        pos = 0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit bad;
        void'($urandom(32'h1F0C_2A77));

        // R1: reset state
        tick(8);
        chk("R1", "lock in reset", lock_out, 1'b0);
        chk("R1", "track in reset", track_data, 1'b0);
        rst = 1'b0;
        pos = 0;

        // R4 window timing, R5 two-window lock, R2 ratio 8 nominal, R3 in range
        goto(N - 1);
        chk("R4", "track before first boundary", track_data, 1'b0);
        goto(N);
        chk("R4", "track at first boundary", track_data, 1'b1);
        goto(5 * N / 2);
        chk("R5", "lock during confirm", lock_out, 1'b0);
        chk("R5", "track during confirm", track_data, 1'b1);
        goto(7 * N / 2);
        chk("R2", "lock at ratio 8 nominal", lock_out, 1'b1);

        // R8 retiming
        data_in = 1'b1;
        #1;
        chk("R8", "data_out follows 1", data_out, 1'b1);
        tick(1);
        data_in = 1'b0;
        #1;
        chk("R8", "data_out follows 0", data_out, 1'b0);

        // R9 clock mux, offsets avoid clock edges
        clk_sel = 1'b1;
        tick(1);
        bad = 1'b0;
        for (int k = 1; k < 16; k++) begin
            #0.033;
            if (tx_clk !== rec_clk) bad = 1'b1;
        end
        chk("R9", "tx_clk equals rec_clk", bad, 1'b0);
        clk_sel = 1'b0;
        tick(1);
        bad = 1'b0;
        for (int k = 1; k < 16; k++) begin
            #0.033;
            if (tx_clk !== synth_clk) bad = 1'b1;
        end
        chk("R9", "tx_clk equals synth_clk", bad, 1'b0);

        // R6 drop after one failing window, R4 retry cycle
        goto(4 * N);
        rec_half_ps = half_for(2'd0, 3);
        goto(9 * N / 2);
        chk("R6", "still locked during failing window", lock_out, 1'b1);
        goto(11 * N / 2);
        chk("R6", "lock dropped", lock_out, 1'b0);
        chk("R6", "back to training", track_data, 1'b0);
        goto(13 * N / 2);
        chk("R4", "released to data again", track_data, 1'b1);
        goto(15 * N / 2);
        chk("R4", "failed probe returns to training", track_data, 1'b0);

        // R7 carrier override, ratio 10
        div_sel = 2'd1;
        rec_half_ps = half_for(2'd1, 0);
        restart();
        goto(7 * N / 2);
        chk("R2", "lock at ratio 10 nominal", lock_out, 1'b1);
        carrier_ok = 1'b0;
        data_in = 1'b1;
        #1;
        chk("R7", "lock low without carrier", lock_out, 1'b0);
        chk("R7", "track low without carrier", track_data, 1'b0);
        chk("R8", "data_out low without carrier", data_out, 1'b0);
        tick(2);
        data_in = 1'b0;
        carrier_ok = 1'b1;
        pos = 0;
        goto(N - 1);
        chk("R7", "new window after carrier return", track_data, 1'b0);
        goto(N);
        chk("R7", "probe after full new window", track_data, 1'b1);

        // R10 recovered clock stops while locked, ratio 16
        div_sel = 2'd2;
        rec_half_ps = half_for(2'd2, 0);
        restart();
        goto(7 * N / 2);
        chk("R2", "lock at ratio 16 nominal", lock_out, 1'b1);
        goto(4 * N);
        rec_run = 1'b0;
        goto(11 * N / 2);
        chk("R10", "lock lost with stopped clock", lock_out, 1'b0);
        chk("R10", "training with stopped clock", track_data, 1'b0);
        rec_run = 1'b1;

        // random trials: R2 ratio table, R3 tolerance test
        for (int t = 0; t < 12; t++) begin
            logic [1:0] s;
            int kind;
            bit exp_pass;
            s = 2'($urandom % 4);
            kind = 1 + int'($urandom % 4);
            div_sel = s;
            rec_half_ps = half_for(s, kind);
            exp_pass = pass_model(s, rec_half_ps);
            restart();
            goto(5 * N / 2);
            chk("R3", "confirm reached per tolerance", track_data, exp_pass);
            goto(7 * N / 2);
            chk("R3", "lock per tolerance", lock_out, exp_pass);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule